// File: doc/BRIEF.md
# Macro-Op to Micro-Op Cracker

This block sits after instruction decode and turns each decoded macro-op into a short run of simple load/store-style micro-ops. One macro-op enters per valid/ready handshake. It carries an opcode class, a function code, two register fields, a memory operand (base, index, scale, index-enable, and a displacement held in the immediate), an immediate or target, and the address of the next instruction. Micro-ops leave one per handshake on a valid/ready output. Each one carries a flag that marks the final micro-op of its macro-op.

Register-only work passes through as a single micro-op. Memory-operand arithmetic, push, call and return expand into fixed, ordered sequences that a small step counter walks. A scaled address is first computed into a hidden temporary by its own micro-op. The block also merges a compare with a conditional branch into one compare-and-branch micro-op, but only when the branch is offered in the cycle right after the compare was taken. Temporaries use register indices at or above the architectural count. The stack pointer is architectural register 4.

Top module: `uop_cracker`

## Requirements
- R1: Class codes are RR=0, CMP=1, BR=2, MEM_SRC=3, MEM_DST=4, PUSH=5, CALL=6, RET=7. Micro-op codes are ALU=0, ALU_IMM=1, LOAD=2, STORE=3, AGEN=4, CMP=5, BR=6, CMPBR=7, JMP=8, JMPR=9, LDPC=10. Every field not named below is zero. An RR macro-op yields one ALU micro-op with fn=in_fn, dst=rd, src1=rd, src2=rs and last=1. A BR macro-op yields one BR micro-op with fn=in_fn, imm=in_imm and last=1.
- R2: A MEM_SRC macro-op yields two micro-ops. The first is LOAD with dst=T0, src1=address register and imm=displacement. The second is ALU with fn=in_fn, dst=rd, src1=rd, src2=T0 and last=1.
- R3: A MEM_DST macro-op yields three micro-ops. The first is LOAD into T0. The second is ALU with fn=in_fn, dst=T0, src1=T0, src2=rs. The third, with last=1, is STORE with src1=address register, src2=T0 and imm=displacement, which is the same address the LOAD used.
- R4: When in_idx_en=1, a MEM_SRC or MEM_DST sequence is preceded by AGEN with dst=T1, src1=base, src2=index, scale=in_scale and imm=in_imm. The memory micro-ops then use address register T1 with displacement 0. With in_idx_en=0 they use address register base with displacement in_imm.
- R5: A PUSH yields STORE with src1=SP, src2=rs and imm=-4. It is followed by ALU_IMM with dst=SP, src1=SP, imm=-4 and last=1.
- R6: A CALL yields four micro-ops in this order: LDPC with dst=T0 and imm=in_npc; STORE with src1=SP, src2=T0 and imm=-4; ALU_IMM with SP=SP-4; and JMP with imm=in_imm and last=1.
- R7: A RET yields three micro-ops in this order: ALU_IMM with dst=SP, src1=SP and imm=+4; LOAD with dst=T0, src1=SP and imm=-4; and JMPR with src1=T0 and last=1.
- R8: If a BR is valid in the cycle right after a CMP was accepted, it is accepted in that cycle (in_ready=1). The pair then yields a single CMPBR with fn=branch fn, src1=cmp rd, src2=cmp rs, imm=branch imm and last=1.
- R9: If no BR is offered in that cycle, the compare is emitted alone as CMP with fn=cmp fn, src1=rd, src2=rs and last=1. A non-branch macro-op offered in that cycle is not accepted (in_ready=0).
- R10: in_ready stays low while micro-ops of the current macro-op are still pending. The next macro-op can only be taken after the micro-op with last=1 has been accepted. Every expected micro-op is delivered.
- R11: While uop_valid=1 and uop_ready=0, the output micro-op stays valid and unchanged in the next cycle.
- R12: Temporaries are T0=NUM_ARCH and T1=NUM_ARCH+1, both outside the architectural range 0..NUM_ARCH-1 (defaults 16 and 17). Every LOAD, AGEN and LDPC writes a temporary.
- R13: While reset is asserted, uop_valid=0 and in_ready=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Macro-op offered |
| in_ready | output | 1 | Macro-op taken this cycle when valid |
| in_cls | input | 3 | Macro-op class |
| in_fn | input | FN_W | ALU function or branch condition |
| in_rd | input | REG_W | First register (destination / compare left) |
| in_rs | input | REG_W | Second register (source / stored value) |
| in_base | input | REG_W | Memory base register |
| in_idx | input | REG_W | Memory index register |
| in_scale | input | 2 | Index shift amount |
| in_idx_en | input | 1 | Memory operand uses the scaled index |
| in_imm | input | DATA_W | Displacement or branch/call target |
| in_npc | input | DATA_W | Address of the following instruction |
| uop_valid | output | 1 | Micro-op present |
| uop_ready | input | 1 | Downstream takes the micro-op |
| uop_op | output | 4 | Micro-op code |
| uop_fn | output | FN_W | Micro-op function / condition |
| uop_dst | output | REG_W | Destination register |
| uop_src1 | output | REG_W | First source register |
| uop_src2 | output | REG_W | Second source register |
| uop_scale | output | 2 | Index shift for AGEN |
| uop_imm | output | DATA_W | Immediate, displacement or target |
| uop_last | output | 1 | Final micro-op of its macro-op |

## Verification
The first micro-op of an ordinary macro-op is on the outputs in the cycle after its input handshake. For a compare it appears one cycle later, because the cycle after the compare is the fusion window. Each further micro-op of the same macro-op follows in the cycle after the previous output handshake. The bench sets inputs and uop_ready at the falling edge and samples both handshakes shortly after that. Expected micro-ops go into an ordered queue at the moment a macro-op handshake is seen, so they are compared in emission order however many stall cycles come between. Fusion-window outcomes (in_ready for a branch or a non-branch) are checked in exactly the cycle after the compare was taken.

// File: rtl/uop_cracker_pkg.sv
`timescale 1ns/1ps
package uop_cracker_pkg;

    localparam int CLS_W  = 3;
    localparam int OP_W   = 4;
    localparam int STEP_W = 3;

    typedef enum logic [CLS_W-1:0] {
        CLS_RR      = 3'd0,
        CLS_CMP     = 3'd1,
        CLS_BR      = 3'd2,
        CLS_MEM_SRC = 3'd3,
        CLS_MEM_DST = 3'd4,
        CLS_PUSH    = 3'd5,
        CLS_CALL    = 3'd6,
        CLS_RET     = 3'd7
    } cls_e;

    typedef enum logic [OP_W-1:0] {
        UOP_ALU   = 4'd0,
        UOP_ALUI  = 4'd1,
        UOP_LOAD  = 4'd2,
        UOP_STORE = 4'd3,
        UOP_AGEN  = 4'd4,
        UOP_CMP   = 4'd5,
        UOP_BR    = 4'd6,
        UOP_CMPBR = 4'd7,
        UOP_JMP   = 4'd8,
        UOP_JMPR  = 4'd9,
        UOP_LDPC  = 4'd10
    } uop_e;

endpackage

// File: rtl/uop_fuse_gate.sv
`timescale 1ns/1ps
module uop_fuse_gate
    import uop_cracker_pkg::*;
(
    input  logic             busy,
    input  logic             fresh,
    input  logic [CLS_W-1:0] held_cls,
    input  logic             in_valid,
    input  logic [CLS_W-1:0] in_cls,
    output logic             cmp_wait,
    output logic             take_br
);

    always_comb begin
        cmp_wait = busy && fresh && (held_cls == CLS_CMP);
        take_br  = cmp_wait && in_valid && (in_cls == CLS_BR);
    end

endmodule

// File: rtl/uop_seq_gen.sv
`timescale 1ns/1ps
module uop_seq_gen
    import uop_cracker_pkg::*;
#(
    parameter int REG_W    = 5,
    parameter int DATA_W   = 32,
    parameter int FN_W     = 4,
    parameter int NUM_ARCH = 16,
    parameter int SP_IDX   = 4
) (
    input  logic [CLS_W-1:0]  m_cls,
    input  logic [FN_W-1:0]   m_fn,
    input  logic [REG_W-1:0]  m_rd,
    input  logic [REG_W-1:0]  m_rs,
    input  logic [REG_W-1:0]  m_base,
    input  logic [REG_W-1:0]  m_idx,
    input  logic [1:0]        m_sc,
    input  logic              m_ie,
    input  logic [DATA_W-1:0] m_imm,
    input  logic [DATA_W-1:0] m_npc,
    input  logic [STEP_W-1:0] step,
    input  logic              fused,
    input  logic [FN_W-1:0]   br_fn,
    input  logic [DATA_W-1:0] br_imm,
    output logic [OP_W-1:0]   o_op,
    output logic [FN_W-1:0]   o_fn,
    output logic [REG_W-1:0]  o_dst,
    output logic [REG_W-1:0]  o_s1,
    output logic [REG_W-1:0]  o_s2,
    output logic [1:0]        o_sc,
    output logic [DATA_W-1:0] o_imm,
    output logic              o_last
);

    localparam logic [REG_W-1:0]  T0    = REG_W'(NUM_ARCH);
    localparam logic [REG_W-1:0]  T1    = REG_W'(NUM_ARCH + 1);
    localparam logic [REG_W-1:0]  SP    = REG_W'(SP_IDX);
    localparam logic [DATA_W-1:0] NEG4  = ~DATA_W'(3);
    localparam logic [DATA_W-1:0] POS4  = DATA_W'(4);

    logic              is_mem;
    logic              has_agen;
    logic [STEP_W-1:0] k;
    logic [REG_W-1:0]  a_reg;
    logic [DATA_W-1:0] a_disp;

    always_comb begin
        is_mem   = (m_cls == CLS_MEM_SRC) || (m_cls == CLS_MEM_DST);
        has_agen = is_mem && m_ie;
        k        = step - STEP_W'(has_agen);
        a_reg    = has_agen ? T1 : m_base;
        a_disp   = has_agen ? '0 : m_imm;

        o_op   = UOP_ALU;
        o_fn   = '0;
        o_dst  = '0;
        o_s1   = '0;
        o_s2   = '0;
        o_sc   = '0;
        o_imm  = '0;
        o_last = 1'b0;

        if (has_agen && (step == '0)) begin
            o_op  = UOP_AGEN;
            o_dst = T1;
            o_s1  = m_base;
            o_s2  = m_idx;
            o_sc  = m_sc;
            o_imm = m_imm;
        end else begin
            case (m_cls)
                CLS_RR: begin
                    o_op = UOP_ALU; o_fn = m_fn; o_dst = m_rd;
                    o_s1 = m_rd; o_s2 = m_rs; o_last = 1'b1;
                end
                CLS_CMP: begin
                    o_s1 = m_rd; o_s2 = m_rs; o_last = 1'b1;
                    if (fused) begin
                        o_op = UOP_CMPBR; o_fn = br_fn; o_imm = br_imm;
                    end else begin
                        o_op = UOP_CMP; o_fn = m_fn;
                    end
                end
                CLS_BR: begin
                    o_op = UOP_BR; o_fn = m_fn; o_imm = m_imm; o_last = 1'b1;
                end
                CLS_MEM_SRC: begin
                    if (k == '0) begin
                        o_op = UOP_LOAD; o_dst = T0; o_s1 = a_reg; o_imm = a_disp;
                    end else begin
                        o_op = UOP_ALU; o_fn = m_fn; o_dst = m_rd;
                        o_s1 = m_rd; o_s2 = T0; o_last = 1'b1;
                    end
                end
                CLS_MEM_DST: begin
                    case (k)
                        STEP_W'(0): begin
                            o_op = UOP_LOAD; o_dst = T0; o_s1 = a_reg; o_imm = a_disp;
                        end
                        STEP_W'(1): begin
                            o_op = UOP_ALU; o_fn = m_fn; o_dst = T0;
                            o_s1 = T0; o_s2 = m_rs;
                        end
                        default: begin
                            o_op = UOP_STORE; o_s1 = a_reg; o_s2 = T0;
                            o_imm = a_disp; o_last = 1'b1;
                        end
                    endcase
                end
                CLS_PUSH: begin
                    if (k == '0) begin
                        o_op = UOP_STORE; o_s1 = SP; o_s2 = m_rs; o_imm = NEG4;
                    end else begin
                        o_op = UOP_ALUI; o_dst = SP; o_s1 = SP;
                        o_imm = NEG4; o_last = 1'b1;
                    end
                end
                CLS_CALL: begin
                    case (k)
                        STEP_W'(0): begin
                            o_op = UOP_LDPC; o_dst = T0; o_imm = m_npc;
                        end
                        STEP_W'(1): begin
                            o_op = UOP_STORE; o_s1 = SP; o_s2 = T0; o_imm = NEG4;
                        end
                        STEP_W'(2): begin
                            o_op = UOP_ALUI; o_dst = SP; o_s1 = SP; o_imm = NEG4;
                        end
                        default: begin
                            o_op = UOP_JMP; o_imm = m_imm; o_last = 1'b1;
                        end
                    endcase
                end
                default: begin
                    case (k)
                        STEP_W'(0): begin
                            o_op = UOP_ALUI; o_dst = SP; o_s1 = SP; o_imm = POS4;
                        end
                        STEP_W'(1): begin
                            o_op = UOP_LOAD; o_dst = T0; o_s1 = SP; o_imm = NEG4;
                        end
                        default: begin
                            o_op = UOP_JMPR; o_s1 = T0; o_last = 1'b1;
                        end
                    endcase
                end
            endcase
        end
    end

endmodule

// File: rtl/uop_cracker.sv
`timescale 1ns/1ps
module uop_cracker
    import uop_cracker_pkg::*;
#(
    parameter int REG_W    = 5,
    parameter int DATA_W   = 32,
    parameter int FN_W     = 4,
    parameter int NUM_ARCH = 16,
    parameter int SP_IDX   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [CLS_W-1:0]  in_cls,
    input  logic [FN_W-1:0]   in_fn,
    input  logic [REG_W-1:0]  in_rd,
    input  logic [REG_W-1:0]  in_rs,
    input  logic [REG_W-1:0]  in_base,
    input  logic [REG_W-1:0]  in_idx,
    input  logic [1:0]        in_scale,
    input  logic              in_idx_en,
    input  logic [DATA_W-1:0] in_imm,
    input  logic [DATA_W-1:0] in_npc,
    output logic              uop_valid,
    input  logic              uop_ready,
    output logic [OP_W-1:0]   uop_op,
    output logic [FN_W-1:0]   uop_fn,
    output logic [REG_W-1:0]  uop_dst,
    output logic [REG_W-1:0]  uop_src1,
    output logic [REG_W-1:0]  uop_src2,
    output logic [1:0]        uop_scale,
    output logic [DATA_W-1:0] uop_imm,
    output logic              uop_last
);

    typedef struct packed {
        logic              busy;
        logic              fresh;
        logic              fused;
        logic [STEP_W-1:0] step;
        logic [CLS_W-1:0]  cls;
        logic [FN_W-1:0]   fn;
        logic [REG_W-1:0]  rd;
        logic [REG_W-1:0]  rs;
        logic [REG_W-1:0]  base;
        logic [REG_W-1:0]  idx;
        logic [1:0]        sc;
        logic              ie;
        logic [DATA_W-1:0] imm;
        logic [DATA_W-1:0] npc;
        logic [FN_W-1:0]   br_fn;
        logic [DATA_W-1:0] br_imm;
    } state_t;

    state_t st_q, st_d;
    logic   cmp_wait, take_br, fire;

    uop_fuse_gate u_fuse (
        .busy     (st_q.busy),
        .fresh    (st_q.fresh),
        .held_cls (st_q.cls),
        .in_valid (in_valid),
        .in_cls   (in_cls),
        .cmp_wait (cmp_wait),
        .take_br  (take_br)
    );

    uop_seq_gen #(
        .REG_W(REG_W), .DATA_W(DATA_W), .FN_W(FN_W),
        .NUM_ARCH(NUM_ARCH), .SP_IDX(SP_IDX)
    ) u_seq (
        .m_cls  (st_q.cls),
        .m_fn   (st_q.fn),
        .m_rd   (st_q.rd),
        .m_rs   (st_q.rs),
        .m_base (st_q.base),
        .m_idx  (st_q.idx),
        .m_sc   (st_q.sc),
        .m_ie   (st_q.ie),
        .m_imm  (st_q.imm),
        .m_npc  (st_q.npc),
        .step   (st_q.step),
        .fused  (st_q.fused),
        .br_fn  (st_q.br_fn),
        .br_imm (st_q.br_imm),
        .o_op   (uop_op),
        .o_fn   (uop_fn),
        .o_dst  (uop_dst),
        .o_s1   (uop_src1),
        .o_s2   (uop_src2),
        .o_sc   (uop_scale),
        .o_imm  (uop_imm),
        .o_last (uop_last)
    );

    always_comb begin
        in_ready  = !st_q.busy || take_br;
        uop_valid = st_q.busy && !cmp_wait;
        fire      = uop_valid && uop_ready;

        st_d       = st_q;
        st_d.fresh = 1'b0;

        if (in_valid && !st_q.busy) begin
            st_d.busy  = 1'b1;
            st_d.fresh = 1'b1;
            st_d.fused = 1'b0;
            st_d.step  = '0;
            st_d.cls   = in_cls;
            st_d.fn    = in_fn;
            st_d.rd    = in_rd;
            st_d.rs    = in_rs;
            st_d.base  = in_base;
            st_d.idx   = in_idx;
            st_d.sc    = in_scale;
            st_d.ie    = in_idx_en;
            st_d.imm   = in_imm;
            st_d.npc   = in_npc;
        end

        if (take_br) begin
            st_d.fused  = 1'b1;
            st_d.br_fn  = in_fn;
            st_d.br_imm = in_imm;
        end

        if (fire) begin
            if (uop_last) st_d.busy = 1'b0;
            else          st_d.step = st_q.step + STEP_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/uop_cracker_chk.sv
`timescale 1ns/1ps
module uop_cracker_chk
    import uop_cracker_pkg::*;
#(
    parameter int REG_W    = 5,
    parameter int DATA_W   = 32,
    parameter int FN_W     = 4,
    parameter int NUM_ARCH = 16,
    parameter int SP_IDX   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              uop_valid,
    input logic              uop_ready,
    input logic [OP_W-1:0]   uop_op,
    input logic [FN_W-1:0]   uop_fn,
    input logic [REG_W-1:0]  uop_dst,
    input logic [REG_W-1:0]  uop_src1,
    input logic [REG_W-1:0]  uop_src2,
    input logic [1:0]        uop_scale,
    input logic [DATA_W-1:0] uop_imm,
    input logic              uop_last
);

    // R10
    take_only_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> !uop_valid);

    // R10
    gap_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && uop_ready && uop_last) |=> !uop_valid);

    // R11
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && !uop_ready) |=> (uop_valid && $stable(uop_op) && $stable(uop_fn)
            && $stable(uop_dst) && $stable(uop_src1) && $stable(uop_src2)
            && $stable(uop_scale) && $stable(uop_imm) && $stable(uop_last)));

    // R12
    temp_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && (uop_op == UOP_LOAD || uop_op == UOP_AGEN || uop_op == UOP_LDPC))
            |-> (uop_dst >= REG_W'(NUM_ARCH)));

    // R5
    sp_adjust_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && uop_op == UOP_ALUI)
            |-> (uop_dst == REG_W'(SP_IDX) && uop_src1 == REG_W'(SP_IDX)));

    // R8
    transfer_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && (uop_op == UOP_BR || uop_op == UOP_CMPBR
            || uop_op == UOP_JMP || uop_op == UOP_JMPR)) |-> uop_last);

    // R13
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |-> (!uop_valid && in_ready));

endmodule

bind uop_cracker uop_cracker_chk #(
    .REG_W(REG_W), .DATA_W(DATA_W), .FN_W(FN_W),
    .NUM_ARCH(NUM_ARCH), .SP_IDX(SP_IDX)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .uop_valid (uop_valid),
    .uop_ready (uop_ready),
    .uop_op    (uop_op),
    .uop_fn    (uop_fn),
    .uop_dst   (uop_dst),
    .uop_src1  (uop_src1),
    .uop_src2  (uop_src2),
    .uop_scale (uop_scale),
    .uop_imm   (uop_imm),
    .uop_last  (uop_last)
);

// File: tb/uop_cracker_test.sv
`timescale 1ns/1ps
module uop_cracker_test;

    localparam logic [2:0] C_RR = 3'd0, C_CMP = 3'd1, C_BR = 3'd2, C_MS = 3'd3,
                           C_MD = 3'd4, C_PUSH = 3'd5, C_CALL = 3'd6, C_RET = 3'd7;
    localparam logic [3:0] U_ALU = 4'd0, U_ALUI = 4'd1, U_LD = 4'd2, U_ST = 4'd3,
                           U_AGEN = 4'd4, U_CMP = 4'd5, U_BR = 4'd6, U_CMPBR = 4'd7,
                           U_JMP = 4'd8, U_JMPR = 4'd9, U_LDPC = 4'd10;
    localparam logic [4:0]  SP = 5'd4, T0 = 5'd16, T1 = 5'd17;
    localparam logic [31:0] M4 = 32'hFFFF_FFFC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_ready;
    logic [2:0]  in_cls = '0;
    logic [3:0]  in_fn = '0;
    logic [4:0]  in_rd = '0, in_rs = '0, in_base = '0, in_idx = '0;
    logic [1:0]  in_scale = '0;
    logic        in_idx_en = 1'b0;
    logic [31:0] in_imm = '0, in_npc = '0;
    logic        uop_valid, uop_ready = 1'b0;
    logic [3:0]  uop_op, uop_fn;
    logic [4:0]  uop_dst, uop_src1, uop_src2;
    logic [1:0]  uop_scale;
    logic [31:0] uop_imm;
    logic        uop_last;

    uop_cracker uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_cls(in_cls), .in_fn(in_fn), .in_rd(in_rd), .in_rs(in_rs),
        .in_base(in_base), .in_idx(in_idx), .in_scale(in_scale),
        .in_idx_en(in_idx_en), .in_imm(in_imm), .in_npc(in_npc),
        .uop_valid(uop_valid), .uop_ready(uop_ready), .uop_op(uop_op),
        .uop_fn(uop_fn), .uop_dst(uop_dst), .uop_src1(uop_src1),
        .uop_src2(uop_src2), .uop_scale(uop_scale), .uop_imm(uop_imm),
        .uop_last(uop_last)
    );

    always #10 clk = ~clk;

    int          n_chk = 0, n_fail = 0;
    int          rdy_pct = 100;
    logic [57:0] exp_q[$];
    string       tag_q[$];
    bit          acc;
    bit          hold_v = 1'b0;
    logic [4:0]  h_rd, h_rs;
    logic [3:0]  h_fn;
    bit          prev_stall = 1'b0;
    logic [57:0] stall_val;

    function automatic logic [57:0] pk(input logic [3:0] op, input logic [3:0] fn,
        input logic [4:0] d, input logic [4:0] s1, input logic [4:0] s2,
        input logic [1:0] sc, input logic [31:0] imm, input logic last);
        return {op, fn, d, s1, s2, sc, imm, last};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, expv, $time);
        end
    endtask

    task automatic push(input logic [3:0] op, input logic [3:0] fn, input logic [4:0] d,
        input logic [4:0] s1, input logic [4:0] s2, input logic [1:0] sc,
        input logic [31:0] imm, input logic last, input string tag);
        exp_q.push_back(pk(op, fn, d, s1, s2, sc, imm, last));
        tag_q.push_back(tag);
    endtask

    task automatic expand();
        logic [4:0]  ar;
        logic [31:0] ad;
        case (in_cls)
            C_RR:  push(U_ALU, in_fn, in_rd, in_rd, in_rs, 0, 0, 1, "R1");
            C_CMP: begin hold_v = 1'b1; h_rd = in_rd; h_rs = in_rs; h_fn = in_fn; end
            C_BR:  push(U_BR, in_fn, 0, 0, 0, 0, in_imm, 1, "R1");
            C_MS, C_MD: begin
                ar = in_base; ad = in_imm;
                if (in_idx_en) begin
                    push(U_AGEN, 0, T1, in_base, in_idx, in_scale, in_imm, 0, "R4");
                    ar = T1; ad = '0;
                end
                if (in_cls == C_MS) begin
                    push(U_LD, 0, T0, ar, 0, 0, ad, 0, "R2");
                    push(U_ALU, in_fn, in_rd, in_rd, T0, 0, 0, 1, "R2");
                end else begin
                    push(U_LD, 0, T0, ar, 0, 0, ad, 0, "R3");
                    push(U_ALU, in_fn, T0, T0, in_rs, 0, 0, 0, "R3");
                    push(U_ST, 0, 0, ar, T0, 0, ad, 1, "R3");
                end
            end
            C_PUSH: begin
                push(U_ST, 0, 0, SP, in_rs, 0, M4, 0, "R5");
                push(U_ALUI, 0, SP, SP, 0, 0, M4, 1, "R5");
            end
            C_CALL: begin
                push(U_LDPC, 0, T0, 0, 0, 0, in_npc, 0, "R6");
                push(U_ST, 0, 0, SP, T0, 0, M4, 0, "R6");
                push(U_ALUI, 0, SP, SP, 0, 0, M4, 0, "R6");
                push(U_JMP, 0, 0, 0, 0, 0, in_imm, 1, "R6");
            end
            default: begin
                push(U_ALUI, 0, SP, SP, 0, 0, 32'd4, 0, "R7");
                push(U_LD, 0, T0, SP, 0, 0, M4, 0, "R7");
                push(U_JMPR, 0, 0, T0, 0, 0, 0, 1, "R7");
            end
        endcase
    endtask

    task automatic observe();
        logic [57:0] act;
        logic [57:0] e;
        string       t;
        bit          fused_now = 1'b0;
        act = pk(uop_op, uop_fn, uop_dst, uop_src1, uop_src2, uop_scale, uop_imm, uop_last);
        if (prev_stall)  // R11
            chk(uop_valid && act == stall_val, "R11 stall hold", {6'd0, act}, {6'd0, stall_val});
        if (uop_valid)   // R10
            chk(!in_ready, "R10 ready low while busy", {63'd0, in_ready}, 64'd0);
        if (uop_valid && uop_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected uop", {6'd0, act}, 64'd0);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(act == e, t, {6'd0, act}, {6'd0, e});
            end
            if (uop_op == U_LD || uop_op == U_AGEN || uop_op == U_LDPC)  // R12
                chk(uop_dst >= T0, "R12 temp dest", {59'd0, uop_dst}, {59'd0, T0});
        end
        prev_stall = uop_valid && !uop_ready;
        stall_val  = act;

        acc = in_valid && in_ready;
        if (hold_v) begin
            hold_v = 1'b0;
            if (in_valid && in_cls == C_BR)       // R8
                chk(in_ready, "R8 branch taken in window", {63'd0, in_ready}, 64'd1);
            else if (in_valid)                    // R9
                chk(!in_ready, "R9 non-branch held", {63'd0, in_ready}, 64'd0);
            if (acc && in_cls == C_BR) begin
                push(U_CMPBR, in_fn, 0, h_rd, h_rs, 0, in_imm, 1, "R8");
                fused_now = 1'b1;
            end else begin
                push(U_CMP, h_fn, 0, h_rd, h_rs, 0, 0, 1, "R9");
            end
        end
        if (acc && !fused_now) expand();
    endtask

    task automatic cycle_step();
        uop_ready = ($urandom % 100) < rdy_pct;
        #1;
        observe();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send(input logic [2:0] cls, input logic [3:0] fn, input logic [4:0] rd,
        input logic [4:0] rs, input logic [4:0] base, input logic [4:0] idx,
        input logic [1:0] sc, input logic ie, input logic [31:0] imm, input logic [31:0] npc);
        in_valid = 1'b1; in_cls = cls; in_fn = fn; in_rd = rd; in_rs = rs;
        in_base = base; in_idx = idx; in_scale = sc; in_idx_en = ie;
        in_imm = imm; in_npc = npc;
        do cycle_step(); while (!acc);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) cycle_step();
    endtask

    task automatic send_rand(input bit no_branch);
        logic [2:0] c;
        c = 3'($urandom_range(0, 7));
        if (no_branch && c == C_BR) c = C_RR;
        send(c, 4'($urandom), 5'($urandom % 16), 5'($urandom % 16), 5'($urandom % 16),
             5'($urandom % 16), 2'($urandom), 1'($urandom), $urandom, $urandom);
    endtask

    initial begin
        #(20 * 150000);
        chk(1'b0, "R10 watchdog expired", 64'd0, 64'd1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        #1;
        // R13: idle during reset
        chk(!uop_valid, "R13 uop_valid in reset", {63'd0, uop_valid}, 64'd0);
        chk(in_ready, "R13 in_ready in reset", {63'd0, in_ready}, 64'd1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        rdy_pct = 100;
        send(C_RR,   4'd3, 5'd1, 5'd2, 0, 0, 0, 0, 0, 0);                        // R1
        send(C_BR,   4'd5, 0, 0, 0, 0, 0, 0, 32'h0000_1000, 0);                  // R1
        send(C_MS,   4'd1, 5'd7, 0, 5'd8, 0, 0, 0, 32'h10, 0);                   // R2
        send(C_MS,   4'd2, 5'd7, 0, 5'd8, 5'd9, 2'd3, 1, 32'h20, 0);             // R4
        send(C_MD,   4'd4, 0, 5'd3, 5'd5, 5'd6, 2'd2, 1, 32'h40, 0);             // R4
        send(C_MD,   4'd6, 0, 5'd3, 5'd5, 0, 0, 0, 32'hFFFF_FFF0, 0);            // R3
        send(C_PUSH, 0, 0, 5'd11, 0, 0, 0, 0, 0, 0);                             // R5
        send(C_CALL, 0, 0, 0, 0, 0, 0, 0, 32'h0000_2000, 32'h0000_0104);         // R6
        send(C_RET,  0, 0, 0, 0, 0, 0, 0, 0, 0);                                 // R7
        send(C_CMP,  4'd9, 5'd1, 5'd2, 0, 0, 0, 0, 0, 0);                        // R8
        send(C_BR,   4'd2, 0, 0, 0, 0, 0, 0, 32'h0000_0300, 0);
        send(C_CMP,  4'd9, 5'd3, 5'd4, 0, 0, 0, 0, 0, 0);                        // R9
        idle(1);
        send(C_BR,   4'd1, 0, 0, 0, 0, 0, 0, 32'h0000_0400, 0);
        send(C_CMP,  4'd7, 5'd5, 5'd6, 0, 0, 0, 0, 0, 0);                        // R9
        send(C_RR,   4'd8, 5'd12, 5'd13, 0, 0, 0, 0, 0, 0);
        rdy_pct = 40;                                                            // R11
        send(C_CALL, 0, 0, 0, 0, 0, 0, 0, 32'h0000_5000, 32'h0000_0200);
        send(C_MD,   4'd3, 0, 5'd2, 5'd1, 5'd15, 2'd1, 1, 32'h8, 0);

        rdy_pct = 70;
        for (int i = 0; i < 400; i++) begin
            send_rand(1'b0);
            if (in_cls == C_CMP) begin
                case ($urandom % 4)
                    0, 1:    send(C_BR, 4'($urandom), 0, 0, 0, 0, 0, 0, $urandom, 0);
                    2:       send_rand(1'b1);
                    default: idle(1);
                endcase
            end else begin
                idle(int'($urandom % 3));
            end
        end

        rdy_pct = 100;
        for (int i = 0; i < 50 && (exp_q.size() != 0 || uop_valid); i++) idle(1);
        // R10: every expected micro-op delivered
        chk(exp_q.size() == 0, "R10 drain", 64'(exp_q.size()), 64'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule